// File: doc/BRIEF.md
# Bus-Mapped Serial Port with Reloadable Baud Scaler

This block is a serial port for a simple peripheral bus. It has select, enable and write strobes, a 5-bit byte address and 32-bit data. Software writes a byte into a one-entry transmit holding register. The block moves that byte into a shift engine and sends it as an asynchronous frame: a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one high stop bit. The receive engine finds frames on the serial input. It checks each bit at the middle of the bit and places the byte in a one-entry receive register. It raises sticky flags for parity, framing, overrun and break conditions.

Bit timing comes from a 12-bit reload counter. The counter gives one tick every (reload+1) clocks. Each bit lasts eight ticks. A loopback switch connects the transmitter to the receiver inside the block. With flow control on, the transmitter waits for the peer-ready input before it starts a frame, and the local-ready output drops while an unread byte is held. One interrupt line combines the receive-ready and transmit-empty conditions, each behind its own enable bit.

Register map by byte offset:
- 0x0: data (bits 7:0).
- 0x4: status (bit0 rx ready, bit1 tx shifter idle, bit2 tx holding empty, bit3 break, bit4 overrun, bit5 parity error, bit6 framing error).
- 0x8: control (bit0 rx enable, bit1 tx enable, bit2 rx interrupt enable, bit3 tx interrupt enable, bit4 odd parity, bit5 parity enable, bit6 flow control, bit7 loopback; bit31 and all other bits read 0).
- 0xC: scaler (bits 11:0).

Top module: `sport_apb`

## Requirements
- R1: After reset, status reads 0x06, control reads 0, scaler reads 0, data reads 0. The serial output, the local-ready output and the interrupt line are at 1, 1 and 0.
- R2: Control keeps only bits 7:0, so bit 31 reads 0 after writing all ones. The scaler keeps bits 11:0.
- R3: The serial output idles high. A frame is a low start bit, then 8 data bits least significant bit first, then a high stop bit.
- R4: With parity enable (control bit5) set, a parity bit follows the data bits. It makes the count of ones even when control bit4 is 0 and odd when bit4 is 1. With parity enable clear, no parity bit is sent.
- R5: A received frame sets status bit0 and the byte reads at offset 0x0. A read of offset 0x0 clears bit0. With rx enable clear, frames are ignored.
- R6: A received parity bit that does not match the configured parity sets status bit5. The byte is still delivered.
- R7: A frame that completes while status bit0 is set sets status bit4, and the new byte is dropped.
- R8: A low stop bit sets status bit6, and the byte is still delivered. If the data bits, any parity bit and the stop bit are all low, status bit3 is set instead and no byte is delivered.
- R9: Any write to status clears bits 3 to 6 and leaves bit0 unchanged.
- R10: In loopback (control bit7), the receiver takes the transmitter output and ignores the serial input.
- R11: With flow control (control bit6), no frame starts while peer-ready is low. Local-ready is low while status bit0 is set.
- R12: The interrupt line is high when (control bit2 and status bit0) or (control bit3 and status bit2).
- R13: One data bit lasts exactly (reload+1)*8 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| peer_ready | input | 1 | Far end may accept data (flow control) |
| local_ready | output | 1 | Low while a received byte is unread under flow control |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest conditions to reach are those that need a frame to complete while the receive register is still full, or a line held low through the stop bit. The bench reaches them by driving whole frames into the serial input from a bit-accurate driver while holding back the data-register read. It also drives frames with a forced low stop bit, both with nonzero data and with all zeros. Holding peer-ready low under flow control keeps the holding register full, so the masked interrupt state and the blocked transmitter can both be observed at the ports.

// File: rtl/sport_pkg.sv
package sport_pkg;

   // frame sequencer states shared by both engines
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_PAR,
      FR_STOP,
      FR_HOLD
   } frame_st_t;

   // register word index (byte offset bits 3:2)
   localparam logic [1:0] REG_DATA = 2'd0;
   localparam logic [1:0] REG_STAT = 2'd1;
   localparam logic [1:0] REG_CTRL = 2'd2;
   localparam logic [1:0] REG_SCAL = 2'd3;

   // control byte, MSB first
   typedef struct packed {
      logic loop_en;
      logic flow_en;
      logic par_en;
      logic par_odd;
      logic tx_ie;
      logic rx_ie;
      logic tx_en;
      logic rx_en;
   } ctrl_t;

endpackage

// File: rtl/sport_tick.sv
module sport_tick #(
   parameter int unsigned SCALER_W = 12
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SCALER_W-1:0] reload,
   output logic                tick
);

   logic [SCALER_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt == '0)
         cnt <= reload;
      else
         cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);

endmodule

// File: rtl/sport_tx.sv
module sport_tx
   import sport_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 8
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       load,
   input  logic [7:0] din,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       line,
   output logic       busy
);

   localparam int unsigned PH_W = $clog2(OVERSAMPLE);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

   frame_st_t       st;
   logic [PH_W-1:0] ph;
   logic [2:0]      bitn;
   logic [7:0]      sh;
   logic            pb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= FR_IDLE;
         ph   <= '0;
         bitn <= '0;
         sh   <= '0;
         pb   <= 1'b0;
      end else if (st == FR_IDLE) begin
         if (load) begin
            st   <= FR_START;
            ph   <= '0;
            bitn <= '0;
            sh   <= din;
            pb   <= (^din) ^ par_odd;
         end
      end else if (tick) begin
         if (ph != PH_LAST) begin
            ph <= ph + 1'b1;
         end else begin
            ph <= '0;
            case (st)
               FR_START: st <= FR_DATA;
               FR_DATA: begin
                  sh   <= sh >> 1;
                  bitn <= bitn + 1'b1;
                  if (bitn == 3'd7)
                     st <= par_en ? FR_PAR : FR_STOP;
               end
               FR_PAR:  st <= FR_STOP;
               default: st <= FR_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         FR_START: line = 1'b0;
         FR_DATA:  line = sh[0];
         FR_PAR:   line = pb;
         default:  line = 1'b1;
      endcase
   end

   assign busy = (st != FR_IDLE);

endmodule

// File: rtl/sport_rx.sv
module sport_rx
   import sport_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 8
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic       enable,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       done,
   output logic [7:0] dout,
   output logic       perr,
   output logic       ferr,
   output logic       brk
);

   localparam int unsigned PH_W = $clog2(OVERSAMPLE);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);

   frame_st_t       st;
   logic [PH_W-1:0] ph;
   logic [2:0]      bitn;
   logic [7:0]      sh;
   logic            pb;
   logic            all_low;

   // data, parity (if any) all zero: candidate break
   assign all_low = (sh == 8'h00) && (!par_en || !pb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= FR_IDLE;
         ph   <= '0;
         bitn <= '0;
         sh   <= '0;
         pb   <= 1'b0;
         done <= 1'b0;
         dout <= '0;
         perr <= 1'b0;
         ferr <= 1'b0;
         brk  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            st <= FR_IDLE;
         end else begin
            case (st)
               FR_IDLE: begin
                  if (tick && !line) begin
                     st <= FR_START;
                     ph <= '0;
                  end
               end
               FR_HOLD: begin
                  if (line)
                     st <= FR_IDLE;
               end
               default: begin
                  if (tick) begin
                     if (ph == PH_MID) begin
                        case (st)
                           FR_START: if (line) st <= FR_IDLE;
                           FR_DATA:  sh <= {line, sh[7:1]};
                           FR_PAR:   pb <= line;
                           FR_STOP: begin
                              done <= 1'b1;
                              dout <= sh;
                              perr <= par_en && (pb != ((^sh) ^ par_odd));
                              ferr <= !line && !all_low;
                              brk  <= !line && all_low;
                              st   <= line ? FR_IDLE : FR_HOLD;
                           end
                           default: ;
                        endcase
                     end
                     if (ph != PH_LAST) begin
                        ph <= ph + 1'b1;
                     end else begin
                        ph <= '0;
                        case (st)
                           FR_START: begin
                              st   <= FR_DATA;
                              bitn <= '0;
                           end
                           FR_DATA: begin
                              bitn <= bitn + 1'b1;
                              if (bitn == 3'd7)
                                 st <= par_en ? FR_PAR : FR_STOP;
                           end
                           FR_PAR:  st <= FR_STOP;
                           default: ;
                        endcase
                     end
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/sport_apb.sv
module sport_apb
   import sport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SCALER_W    = 12,
   parameter int unsigned OVERSAMPLE  = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [SCALER_W-1:0] SCALER_RST = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              ser_in,
   output logic              ser_out,
   input  logic              peer_ready,
   output logic              local_ready,
   output logic              irq
);

   // elaboration-time parameter checks
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (SCALER_W < 2 || SCALER_W > DATA_W) begin : g_bad_scal
         $error("SCALER_W must lie between 2 and DATA_W");
      end
      if (ADDR_W < 4 || DATA_W < 8 || SYNC_STAGES < 1) begin : g_bad_bus
         $error("bus or synchronizer parameters too small");
      end
   endgenerate

   // bus decode
   logic       reg_hit;
   logic [1:0] word;
   logic       acc_wr, acc_rd;
   logic       wr_data, wr_ctrl, wr_scal, stat_wr, rd_data;

   assign reg_hit = ((paddr >> 4) == '0);
   assign word    = paddr[3:2];
   assign acc_wr  = psel && penable && pwrite && reg_hit;
   assign acc_rd  = psel && penable && !pwrite && reg_hit;
   assign wr_data = acc_wr && (word == REG_DATA);
   assign stat_wr = acc_wr && (word == REG_STAT);
   assign wr_ctrl = acc_wr && (word == REG_CTRL);
   assign wr_scal = acc_wr && (word == REG_SCAL);
   assign rd_data = acc_rd && (word == REG_DATA);

   logic unused_bits;
   assign unused_bits = ^{paddr[1:0], pwdata};

   // registers and flags
   ctrl_t               ctrl;
   logic [SCALER_W-1:0] scaler;
   logic [7:0]          thr;
   logic                thr_full;
   logic [7:0]          rbr;
   logic                dr, ov, fe, pe, brk_f;
   logic                flow_en;

   assign flow_en = ctrl.flow_en;

   // engine interconnect
   logic       tick;
   logic       tx_load, tx_busy, tx_line;
   logic       rx_src, rx_line;
   logic       rx_done, rx_perr, rx_ferr, rx_brk;
   logic [7:0] rx_byte;

   assign tx_load = ctrl.tx_en && thr_full && !tx_busy && (!ctrl.flow_en || peer_ready);

   sport_tick #(.SCALER_W(SCALER_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (scaler),
      .tick   (tick)
   );

   sport_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load    (tx_load),
      .din     (thr),
      .par_en  (ctrl.par_en),
      .par_odd (ctrl.par_odd),
      .line    (tx_line),
      .busy    (tx_busy)
   );

   assign ser_out = tx_line;
   assign rx_src  = ctrl.loop_en ? tx_line : ser_in;

   // receive line synchronizer; depth picks the variant
   logic [SYNC_STAGES-1:0] sync_q;
   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rx_src;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_src};
         end
      end
   endgenerate
   assign rx_line = sync_q[SYNC_STAGES-1];

   sport_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .line    (rx_line),
      .enable  (ctrl.rx_en),
      .par_en  (ctrl.par_en),
      .par_odd (ctrl.par_odd),
      .done    (rx_done),
      .dout    (rx_byte),
      .perr    (rx_perr),
      .ferr    (rx_ferr),
      .brk     (rx_brk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         scaler   <= SCALER_RST;
         thr      <= '0;
         thr_full <= 1'b0;
         rbr      <= '0;
         dr       <= 1'b0;
         ov       <= 1'b0;
         fe       <= 1'b0;
         pe       <= 1'b0;
         brk_f    <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl   <= ctrl_t'(pwdata[7:0]);
         if (wr_scal) scaler <= pwdata[SCALER_W-1:0];

         if (wr_data) begin
            thr      <= pwdata[7:0];
            thr_full <= 1'b1;
         end else if (tx_load) begin
            thr_full <= 1'b0;
         end

         if (rd_data) dr <= 1'b0;

         if (stat_wr) begin
            fe    <= 1'b0;
            pe    <= 1'b0;
            ov    <= 1'b0;
            brk_f <= 1'b0;
         end

         if (rx_done) begin
            if (rx_brk) begin
               brk_f <= 1'b1;
            end else if (dr && !rd_data) begin
               ov <= 1'b1;
            end else begin
               rbr <= rx_byte;
               dr  <= 1'b1;
               if (rx_perr) pe <= 1'b1;
               if (rx_ferr) fe <= 1'b1;
            end
         end
      end
   end

   // read mux
   always_comb begin
      prdata = '0;
      if (reg_hit) begin
         case (word)
            REG_DATA: prdata[7:0] = rbr;
            REG_STAT: prdata[6:0] = {fe, pe, ov, brk_f, !thr_full, !tx_busy, dr};
            REG_CTRL: prdata[7:0] = ctrl;
            default:  prdata[SCALER_W-1:0] = scaler;
         endcase
      end
   end

   assign local_ready = !(ctrl.flow_en && dr);
   assign irq         = (ctrl.rx_ie && dr) || (ctrl.tx_ie && !thr_full);

endmodule

// File: rtl/sport_chk.sv
module sport_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_data,
   input logic stat_wr,
   input logic rx_done,
   input logic rx_brk,
   input logic dr,
   input logic ov,
   input logic fe,
   input logic pe,
   input logic brk_f,
   input logic flow_en,
   input logic peer_ready,
   input logic tx_busy,
   input logic ser_out
);

   // R5
   rd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !dr);

   // R7
   overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_brk && dr && !rd_data) |=> ov);

   // R8
   break_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_brk && !dr) |=> !dr);

   // R9
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !rx_done) |=> !(fe || pe || ov || brk_f));

   // R11
   peer_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && !peer_ready && !tx_busy) |=> !tx_busy);

   // R3
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> ser_out);

endmodule

bind sport_apb sport_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_data    (rd_data),
   .stat_wr    (stat_wr),
   .rx_done    (rx_done),
   .rx_brk     (rx_brk),
   .dr         (dr),
   .ov         (ov),
   .fe         (fe),
   .pe         (pe),
   .brk_f      (brk_f),
   .flow_en    (flow_en),
   .peer_ready (peer_ready),
   .tx_busy    (tx_busy),
   .ser_out    (ser_out)
);

// File: tb/sim_sport_apb.sv
module sim_sport_apb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        psel, penable, pwrite;
   logic [4:0]  paddr;
   logic [31:0] pwdata, prdata;
   logic        ser_in, ser_out, peer_ready, local_ready, irq;

   int          n_chk  = 0;
   int          n_fail = 0;
   int unsigned reload = 1;
   bit          finished = 0;

   always #10 clk = ~clk;

   sport_apb u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ser_in(ser_in),
      .ser_out(ser_out), .peer_ready(peer_ready), .local_ready(local_ready), .irq(irq)
   );

   localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08, A_SCAL = 5'h0C;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      #1 d = prdata;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   function automatic int bp();
      return int'((reload + 1) * 8);
   endfunction

   function automatic logic par_of(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic drive_frame(input logic [7:0] d, input bit pen, input logic pbit, input logic stopv);
      @(negedge clk);
      ser_in = 0;
      repeat (bp()) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_in = d[i];
         repeat (bp()) @(negedge clk);
      end
      if (pen) begin
         ser_in = pbit;
         repeat (bp()) @(negedge clk);
      end
      ser_in = stopv;
      repeat (bp()) @(negedge clk);
      ser_in = 1;
      repeat (bp()) @(negedge clk);
   endtask

   task automatic capture(input bit pen, output logic [7:0] d, output logic pb, output logic stp, output bit ok);
      int w = 0;
      ok = 1; d = '0; pb = 0; stp = 0;
      while (ser_out !== 1'b0) begin
         @(negedge clk);
         w++;
         if (w > 20000) begin ok = 0; return; end
      end
      repeat (bp() / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (bp()) @(negedge clk);
         d[i] = ser_out;
      end
      if (pen) begin
         repeat (bp()) @(negedge clk);
         pb = ser_out;
      end
      repeat (bp()) @(negedge clk);
      stp = ser_out;
      repeat (bp()) @(negedge clk);
   endtask

   task automatic wait_level(input logic v, output int cyc);
      cyc = 0;
      while (ser_out !== v && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic measure_bit(input int unsigned r);
      int c0, c1;
      reload = r;
      bus_wr(A_SCAL, r);
      bus_wr(A_CTRL, 32'h02);
      bus_wr(A_DATA, 32'h55);
      wait_level(1'b0, c0);
      wait_level(1'b1, c0);
      wait_level(1'b0, c1);
      // R13: bit0=1 then bit1=0, edge-to-edge is one bit
      check("R13", "bit period cycles", c1, bp());
      repeat (bp() * 11) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  d;
      logic        pb, stp;
      bit          ok;
      int          minline;

      void'($urandom(32'd4242));
      psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
      ser_in = 1; peer_ready = 1; rst_n = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      bus_rd(A_STAT, v); check("R1", "status", v, 32'h06);
      bus_rd(A_CTRL, v); check("R1", "control", v, 32'h0);
      bus_rd(A_SCAL, v); check("R1", "scaler", v, 32'h0);
      bus_rd(A_DATA, v); check("R1", "data", v, 32'h0);
      check("R1", "ser_out", ser_out, 1); check("R1", "local_ready", local_ready, 1);
      check("R1", "irq", irq, 0);

      // R2 field widths
      bus_wr(A_CTRL, 32'hFFFF_FFFF);
      bus_rd(A_CTRL, v); check("R2", "control readback", v, 32'hFF);
      bus_wr(A_SCAL, 32'hFFFF_FFFF);
      bus_rd(A_SCAL, v); check("R2", "scaler readback", v, 32'hFFF);
      bus_wr(A_CTRL, 32'h0);
      reload = 1;
      bus_wr(A_SCAL, reload);

      // R13 bit period at two reloads
      measure_bit(2);
      measure_bit(5);
      reload = 1;
      bus_wr(A_SCAL, reload);

      // R5 receiver disabled ignores frames
      bus_wr(A_CTRL, 32'h02);
      drive_frame(8'hC3, 0, 0, 1);
      bus_rd(A_STAT, v); check("R5", "rx disabled status", v, 32'h06);

      // random mix: R3, R4, R5
      for (int it = 0; it < 8; it++) begin
         logic [7:0] rb;
         bit pen, odd;
         rb  = 8'($urandom);
         pen = 1'($urandom);
         odd = 1'($urandom);
         bus_wr(A_CTRL, 32'h03 | (32'(pen) << 5) | (32'(odd) << 4));
         drive_frame(rb, pen, par_of(rb, odd), 1);
         bus_rd(A_STAT, v); check("R5", "rx ready status", v, 32'h07);
         bus_rd(A_DATA, v); check("R5", "rx byte", v, 32'(rb));
         bus_rd(A_STAT, v); check("R5", "ready cleared by read", v, 32'h06);
         bus_wr(A_DATA, 32'(rb ^ 8'h5A));
         capture(pen, d, pb, stp, ok);
         check("R3", "tx frame seen", ok, 1);
         check("R3", "tx byte", d, rb ^ 8'h5A);
         check("R3", "tx stop", stp, 1);
         if (pen) check("R4", "tx parity", pb, par_of(rb ^ 8'h5A, odd));
      end

      // R4 directed: no parity bit when disabled (stop follows bit 7)
      bus_wr(A_CTRL, 32'h02);
      bus_wr(A_DATA, 32'h00);
      capture(0, d, pb, stp, ok);
      check("R4", "no parity slot, stop high", stp, 1);

      // R6 parity error, even parity
      bus_wr(A_CTRL, 32'h23);
      drive_frame(8'h3C, 1, ~par_of(8'h3C, 0), 1);
      bus_rd(A_STAT, v); check("R6", "parity error status", v, 32'h27);
      bus_rd(A_DATA, v); check("R6", "byte kept", v, 32'h3C);
      bus_wr(A_STAT, 0);
      bus_rd(A_STAT, v); check("R9", "clear after parity", v, 32'h06);

      // R7 overrun
      bus_wr(A_CTRL, 32'h03);
      drive_frame(8'h11, 0, 0, 1);
      drive_frame(8'h22, 0, 0, 1);
      bus_rd(A_STAT, v); check("R7", "overrun status", v, 32'h17);
      bus_rd(A_DATA, v); check("R7", "first byte kept", v, 32'h11);
      bus_rd(A_STAT, v); check("R7", "overrun sticky", v, 32'h16);
      bus_wr(A_STAT, 0);
      bus_rd(A_STAT, v); check("R9", "clear after overrun", v, 32'h06);

      // R8 framing
      drive_frame(8'h5A, 0, 0, 0);
      bus_rd(A_STAT, v); check("R8", "framing status", v, 32'h47);
      // R9 write keeps ready bit
      bus_wr(A_STAT, 32'hFFFF_FFFF);
      bus_rd(A_STAT, v); check("R9", "ready kept on clear", v, 32'h07);
      bus_rd(A_DATA, v); check("R8", "framing byte", v, 32'h5A);

      // R8 break
      drive_frame(8'h00, 0, 0, 0);
      bus_rd(A_STAT, v); check("R8", "break status", v, 32'h0E);
      bus_wr(A_STAT, 0);
      bus_rd(A_STAT, v); check("R9", "clear after break", v, 32'h06);

      // R10 loopback, external line held low
      bus_wr(A_CTRL, 32'h83);
      repeat (4) @(negedge clk);
      ser_in = 0;
      bus_wr(A_DATA, 32'hA7);
      repeat (bp() * 13) @(negedge clk);
      bus_rd(A_STAT, v); check("R10", "loopback status", v, 32'h07);
      bus_rd(A_DATA, v); check("R10", "loopback byte", v, 32'hA7);
      ser_in = 1;
      repeat (4) @(negedge clk);
      bus_wr(A_CTRL, 32'h0);

      // R12 receive interrupt
      bus_wr(A_CTRL, 32'h05);
      check("R12", "irq idle rx", irq, 0);
      drive_frame(8'h81, 0, 0, 1);
      check("R12", "irq on ready", irq, 1);
      bus_rd(A_DATA, v);
      check("R12", "irq after read", irq, 0);

      // R11/R12 flow control blocks transmit
      peer_ready = 0;
      bus_wr(A_CTRL, 32'h4A);
      check("R12", "irq tx empty", irq, 1);
      bus_wr(A_DATA, 32'h96);
      check("R12", "irq tx held", irq, 0);
      minline = 1;
      repeat (bp() * 5) begin
         @(negedge clk);
         if (ser_out !== 1'b1) minline = 0;
      end
      check("R11", "line held while peer not ready", minline, 1);
      bus_rd(A_STAT, v); check("R11", "status while blocked", v, 32'h02);
      peer_ready = 1;
      capture(0, d, pb, stp, ok);
      check("R11", "frame after peer ready", d, 8'h96);
      check("R12", "irq after send", irq, 1);

      // R11 local ready
      bus_wr(A_CTRL, 32'h41);
      check("R11", "local ready idle", local_ready, 1);
      drive_frame(8'h7E, 0, 0, 1);
      check("R11", "local ready held low", local_ready, 0);
      bus_rd(A_DATA, v);
      check("R11", "local ready after read", local_ready, 1);
      bus_wr(A_CTRL, 32'h01);
      drive_frame(8'h7F, 0, 0, 1);
      check("R11", "no flow keeps ready", local_ready, 1);
      bus_rd(A_DATA, v); check("R5", "byte no flow", v, 32'h7F);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule